// File: doc/BRIEF.md
# Fixed-Point Recurrent Inference Engine

This block evaluates a small single-layer recurrent network (Elman form) over a short time series. A host first places the samples in an input memory outside the block and pulses `start`. The engine then walks the sequence one sample at a time. At each step it refreshes a hidden-state vector with a chain of multiply-accumulate operations and a piecewise-linear squashing function. It then forms one prediction from the new hidden state and writes it to an output memory. When the last prediction has been stored, `done` is raised.

All arithmetic is 16-bit signed fixed point with 7 fraction bits. Products are brought back to that scale by an arithmetic right shift, and every product and every sum is clamped to the word range. The weights and biases are elaboration-time constants supplied as packed parameter vectors, so they synthesize to constant logic. One multiply-accumulate is issued per clock. Both memory ports are single-port, and reads return data one cycle after the address is presented.

Top module: `rnn_engine`

## Requirements
- R1: Samples, weights, biases, hidden state and predictions are 16-bit two's-complement words with 7 fraction bits (value 128 represents 1.0).
- R2: A product is formed at full width, shifted right arithmetically by 7 (rounding toward minus infinity), then clamped to the 16-bit range.
- R3: Every product and every sum that leaves the 16-bit range is clamped: positive overflow to 0x7FFF, negative overflow to 0x8000.
- R4: The activation maps a value x with magnitude a to: a when a < 64; (a >> 1) + 32 when 64 <= a < 256; 128 when a >= 256. The result carries the sign of x.
- R5: For each step t, neuron j computes its sum in this exact order: start from bias BH[j], add WX[j]·x_t, then add WH[j][k]·h[k] for k = 0, 1, 2, 3 in ascending order. Each addition is saturating. The new h[j] is the activation of that sum. Every neuron uses the hidden state of the previous step. The hidden state is zero at the start of each run.
- R6: After the hidden update of step t, the prediction is BO + WO[0]·h[0] + ... + WO[3]·h[3], summed in ascending k with saturating adds. It is written once, at output address t, with `out_we` high for one cycle.
- R7: For each step the engine raises `in_rd_en` for one cycle with `in_addr` = t. Steps run through addresses 0 to SEQ-1 in ascending order. The sample is taken from `in_rdata` in the cycle after the read request.
- R8: `done` is low during a run and rises in the cycle after the write to address SEQ-1. It stays high until the next `start`, and it falls in the cycle after that `start` is accepted.
- R9: A `start` pulse that arrives while a run is in progress is ignored. The run's timing, reads, writes and results are unchanged.
- R10: While reset is held and right after it is released, `done`, `in_rd_en` and `out_we` are low.
- R11: Parameter packing: element i of WX, BH and WO occupies bits [16i+15:16i] of its vector. WH[j][k] occupies element j·HID+k of its vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle or done) |
| done | output | 1 | All predictions stored; held until the next start |
| in_rd_en | output | 1 | Read request to the input sample memory |
| in_addr | output | AW | Input memory address (time step) |
| in_rdata | input | WORD_W | Input memory read data, valid one cycle after the request |
| out_we | output | 1 | Write strobe to the output memory |
| out_addr | output | AW | Output memory address (time step) |
| out_wdata | output | WORD_W | Prediction to be written |

## Verification
The hardest situation to reach from the ports is a neuron sum that saturates part way through its chain and then comes back toward range. Because saturation is applied at each add, the final value then depends on the order of the terms. The bench reaches this with full-scale inputs (0x7FFF, 0x8000, alternating signs), weights whose magnitude exceeds 1.0, and a stream of random samples that mixes small values with full-range ones. The small values drive the activation through all three of its segments. A second stimulus pulses `start` in the middle of a run and compares the run length and the results against a clean run.

// File: rtl/rnn_pkg.sv
package rnn_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WAIT,
      ST_HID,
      ST_COMMIT,
      ST_OUT,
      ST_WR,
      ST_DONE
   } rnn_state_e;

endpackage

// File: rtl/rnn_mac.sv
module rnn_mac #(
   parameter int WORD_W = 16,
   parameter int FRAC_W = 7
) (
   input  logic signed [WORD_W-1:0] acc_in,
   input  logic signed [WORD_W-1:0] wgt,
   input  logic signed [WORD_W-1:0] opd,
   output logic signed [WORD_W-1:0] acc_out
);
   localparam int PW = 2 * WORD_W;
   localparam logic signed [WORD_W-1:0] MAXW = {1'b0, {(WORD_W-1){1'b1}}};
   localparam logic signed [WORD_W-1:0] MINW = {1'b1, {(WORD_W-1){1'b0}}};

   generate
      if (FRAC_W < 2 || FRAC_W > WORD_W - 3) begin : g_bad_frac
         $error("rnn_mac: FRAC_W out of range");
      end
   endgenerate

   logic signed [PW-1:0]     prod;
   logic signed [PW-1:0]     scaled;
   logic [PW-WORD_W:0]       top_bits;
   logic signed [WORD_W-1:0] mul_q;
   logic signed [WORD_W:0]   sum;

   always_comb begin
      prod     = wgt * opd;
      scaled   = prod >>> FRAC_W;
      top_bits = scaled[PW-1:WORD_W-1];
      if ((&top_bits) || !(|top_bits)) begin
         mul_q = scaled[WORD_W-1:0];
      end else begin
         mul_q = scaled[PW-1] ? MINW : MAXW;
      end
      sum = {acc_in[WORD_W-1], acc_in} + {mul_q[WORD_W-1], mul_q};
      if (sum[WORD_W] != sum[WORD_W-1]) begin
         acc_out = sum[WORD_W] ? MINW : MAXW;
      end else begin
         acc_out = sum[WORD_W-1:0];
      end
   end
endmodule

// File: rtl/rnn_tanh_pwl.sv
module rnn_tanh_pwl #(
   parameter int WORD_W = 16,
   parameter int FRAC_W = 7
) (
   input  logic signed [WORD_W-1:0] x,
   output logic signed [WORD_W-1:0] y
);
   localparam logic [WORD_W:0] LSB   = (WORD_W+1)'(1);
   localparam logic [WORD_W:0] HALF  = LSB << (FRAC_W - 1);
   localparam logic [WORD_W:0] QUART = LSB << (FRAC_W - 2);
   localparam logic [WORD_W:0] UNIT  = LSB << FRAC_W;
   localparam logic [WORD_W:0] TWO   = LSB << (FRAC_W + 1);

   generate
      if (FRAC_W + 2 >= WORD_W) begin : g_bad_width
         $error("rnn_tanh_pwl: word too narrow for activation range");
      end
   endgenerate

   logic [WORD_W:0] mag;
   logic [WORD_W:0] r;
   logic [WORD_W:0] neg_r;

   always_comb begin
      mag = x[WORD_W-1] ? (~{1'b1, x} + LSB) : {1'b0, x};
      if (mag < HALF) begin
         r = mag;
      end else if (mag < TWO) begin
         r = (mag >> 1) + QUART;
      end else begin
         r = UNIT;
      end
      neg_r = ~r + LSB;
      y     = x[WORD_W-1] ? neg_r[WORD_W-1:0] : r[WORD_W-1:0];
   end
endmodule

// File: rtl/rnn_wsel.sv
module rnn_wsel #(
   parameter int WORD_W = 16,
   parameter int HID    = 4,
   parameter int HW     = 3,
   parameter int JW     = 2,
   parameter logic [HID*WORD_W-1:0]     WX_VEC = '0,
   parameter logic [HID*HID*WORD_W-1:0] WH_VEC = '0,
   parameter logic [HID*WORD_W-1:0]     BH_VEC = '0,
   parameter logic [HID*WORD_W-1:0]     WO_VEC = '0,
   parameter logic [WORD_W-1:0]         BO_VAL = '0
) (
   input  logic                     out_phase,
   input  logic [JW-1:0]            j_idx,
   input  logic [HW-1:0]            m_idx,
   output logic signed [WORD_W-1:0] wgt,
   output logic signed [WORD_W-1:0] bias
);
   logic signed [WORD_W-1:0] wx [HID];
   logic signed [WORD_W-1:0] bh [HID];
   logic signed [WORD_W-1:0] wo [HID];
   logic signed [WORD_W-1:0] wh [HID*HID];

   generate
      for (genvar g = 0; g < HID; g++) begin : g_vec
         assign wx[g] = WX_VEC[g*WORD_W +: WORD_W];
         assign bh[g] = BH_VEC[g*WORD_W +: WORD_W];
         assign wo[g] = WO_VEC[g*WORD_W +: WORD_W];
      end
      for (genvar g = 0; g < HID*HID; g++) begin : g_mat
         assign wh[g] = WH_VEC[g*WORD_W +: WORD_W];
      end
   endgenerate

   always_comb begin
      wgt  = '0;
      bias = '0;
      if (out_phase) begin
         bias = BO_VAL;
         for (int k = 0; k < HID; k++) begin
            if (m_idx == HW'(k)) wgt = wo[k];
         end
      end else begin
         for (int j = 0; j < HID; j++) begin
            if (j_idx == JW'(j)) begin
               bias = bh[j];
               if (m_idx == '0) wgt = wx[j];
               for (int k = 0; k < HID; k++) begin
                  if (m_idx == HW'(k + 1)) wgt = wh[j*HID + k];
               end
            end
         end
      end
   end
endmodule

// File: rtl/rnn_engine.sv
module rnn_engine
   import rnn_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int FRAC_W = 7,
   parameter int HID    = 4,
   parameter int SEQ    = 6,
   parameter logic [HID*WORD_W-1:0] WX_VEC =
      {16'sd96, -16'sd64, 16'sd160, 16'sd128},
   parameter logic [HID*HID*WORD_W-1:0] WH_VEC =
      {16'sd32, -16'sd16, 16'sd64, 16'sd8,
       -16'sd48, 16'sd96, 16'sd0, 16'sd24,
       16'sd16, 16'sd40, -16'sd80, 16'sd12,
       16'sd0, -16'sd20, 16'sd30, 16'sd64},
   parameter logic [HID*WORD_W-1:0] BH_VEC =
      {-16'sd8, 16'sd0, 16'sd12, 16'sd4},
   parameter logic [HID*WORD_W-1:0] WO_VEC =
      {16'sd64, -16'sd96, 16'sd48, 16'sd112},
   parameter logic [WORD_W-1:0] BO_VAL = 16'sd6,
   localparam int AW = (SEQ > 1) ? $clog2(SEQ) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic              in_rd_en,
   output logic [AW-1:0]     in_addr,
   input  logic [WORD_W-1:0] in_rdata,
   output logic              out_we,
   output logic [AW-1:0]     out_addr,
   output logic [WORD_W-1:0] out_wdata
);
   localparam int HW = $clog2(HID + 1);
   localparam int JW = (HID > 1) ? $clog2(HID) : 1;

   generate
      if (HID < 1 || SEQ < 1) begin : g_bad_size
         $error("rnn_engine: HID and SEQ must be at least 1");
      end
   endgenerate

   rnn_state_e st_q;
   logic [AW-1:0]            t_q;
   logic [JW-1:0]            j_q;
   logic [HW-1:0]            m_q;
   logic signed [WORD_W-1:0] x_q;
   logic signed [WORD_W-1:0] acc_q;
   logic signed [WORD_W-1:0] y_q;
   logic signed [WORD_W-1:0] h_q  [HID];
   logic signed [WORD_W-1:0] hn_q [HID];

   logic                     out_phase;
   logic                     busy;
   logic signed [WORD_W-1:0] wgt;
   logic signed [WORD_W-1:0] bias;
   logic signed [WORD_W-1:0] opd;
   logic signed [WORD_W-1:0] acc_in;
   logic signed [WORD_W-1:0] mac_out;
   logic signed [WORD_W-1:0] act_out;

   assign out_phase = (st_q == ST_OUT);
   assign busy      = (st_q != ST_IDLE) && (st_q != ST_DONE);

   rnn_wsel #(
      .WORD_W(WORD_W), .HID(HID), .HW(HW), .JW(JW),
      .WX_VEC(WX_VEC), .WH_VEC(WH_VEC), .BH_VEC(BH_VEC),
      .WO_VEC(WO_VEC), .BO_VAL(BO_VAL)
   ) u_wsel (
      .out_phase(out_phase),
      .j_idx    (j_q),
      .m_idx    (m_q),
      .wgt      (wgt),
      .bias     (bias)
   );

   always_comb begin
      opd = '0;
      if (out_phase) begin
         for (int k = 0; k < HID; k++) begin
            if (m_q == HW'(k)) opd = h_q[k];
         end
      end else begin
         if (m_q == '0) opd = x_q;
         for (int k = 0; k < HID; k++) begin
            if (m_q == HW'(k + 1)) opd = h_q[k];
         end
      end
      acc_in = (m_q == '0) ? bias : acc_q;
   end

   rnn_mac #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_mac (
      .acc_in (acc_in),
      .wgt    (wgt),
      .opd    (opd),
      .acc_out(mac_out)
   );

   rnn_tanh_pwl #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_act (
      .x(mac_out),
      .y(act_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         t_q   <= '0;
         j_q   <= '0;
         m_q   <= '0;
         x_q   <= '0;
         acc_q <= '0;
         y_q   <= '0;
         for (int k = 0; k < HID; k++) begin
            h_q[k]  <= '0;
            hn_q[k] <= '0;
         end
      end else begin
         case (st_q)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  t_q  <= '0;
                  st_q <= ST_RD;
                  for (int k = 0; k < HID; k++) h_q[k] <= '0;
               end
            end
            ST_RD: st_q <= ST_WAIT;
            ST_WAIT: begin
               x_q  <= in_rdata;
               j_q  <= '0;
               m_q  <= '0;
               st_q <= ST_HID;
            end
            ST_HID: begin
               acc_q <= mac_out;
               if (m_q == HW'(HID)) begin
                  for (int k = 0; k < HID; k++) begin
                     if (j_q == JW'(k)) hn_q[k] <= act_out;
                  end
                  m_q <= '0;
                  if (j_q == JW'(HID - 1)) st_q <= ST_COMMIT;
                  else j_q <= j_q + 1'b1;
               end else begin
                  m_q <= m_q + 1'b1;
               end
            end
            ST_COMMIT: begin
               for (int k = 0; k < HID; k++) h_q[k] <= hn_q[k];
               m_q  <= '0;
               st_q <= ST_OUT;
            end
            ST_OUT: begin
               acc_q <= mac_out;
               if (m_q == HW'(HID - 1)) begin
                  y_q  <= mac_out;
                  st_q <= ST_WR;
               end else begin
                  m_q <= m_q + 1'b1;
               end
            end
            ST_WR: begin
               if (t_q == AW'(SEQ - 1)) begin
                  st_q <= ST_DONE;
               end else begin
                  t_q  <= t_q + 1'b1;
                  st_q <= ST_RD;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done      = (st_q == ST_DONE);
   assign in_rd_en  = (st_q == ST_RD);
   assign in_addr   = t_q;
   assign out_we    = (st_q == ST_WR);
   assign out_addr  = t_q;
   assign out_wdata = y_q;

endmodule

// File: rtl/rnn_engine_chk.sv
module rnn_engine_chk #(
   parameter int WORD_W = 16,
   parameter int FRAC_W = 7,
   parameter int SEQ    = 6,
   parameter int AW     = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start,
   input logic                     busy,
   input logic                     done,
   input logic                     in_rd_en,
   input logic [AW-1:0]            in_addr,
   input logic                     out_we,
   input logic [AW-1:0]            out_addr,
   input logic signed [WORD_W-1:0] act_out
);
   localparam int ACT_MAX = (((2 << FRAC_W) - 1) >> 1) + (1 << (FRAC_W - 2));

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(out_we) && ($past(out_addr) == AW'(SEQ - 1))); // R8

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done); // R8

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && !(out_we && out_addr == AW'(SEQ - 1)) |=> busy && !done); // R9

   AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      in_rd_en |-> (in_addr < AW'(SEQ)) && !done); // R7

   AST_ACT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(act_out) <= ACT_MAX) && (int'(act_out) >= -ACT_MAX)); // R4

   AST_WRITE_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      out_we |=> !in_rd_en || (in_addr == $past(out_addr) + 1'b1)); // R7

endmodule

bind rnn_engine rnn_engine_chk #(
   .WORD_W(WORD_W), .FRAC_W(FRAC_W), .SEQ(SEQ), .AW(AW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .in_rd_en(in_rd_en),
   .in_addr (in_addr),
   .out_we  (out_we),
   .out_addr(out_addr),
   .act_out (act_out)
);

// File: tb/rnn_engine_tb.sv
`timescale 1ns/1ps
module rnn_engine_tb;
   localparam int W   = 16;
   localparam int HID = 4;
   localparam int SEQ = 6;
   localparam int AW  = 3;

   typedef logic signed [W-1:0] w16_t;

   localparam logic [HID*W-1:0] TB_WX =
      {16'sd1024, 16'sd64, -16'sd192, 16'sd128};
   localparam logic [HID*HID*W-1:0] TB_WH =
      {16'sd128, -16'sd90, 16'sd77, 16'sd0,
       -16'sd5, 16'sd10, -16'sd300, 16'sd300,
       16'sd200, 16'sd16, 16'sd40, -16'sd128,
       16'sd0, 16'sd96, -16'sd32, 16'sd64};
   localparam logic [HID*W-1:0] TB_BH =
      {16'sd100, 16'sd0, -16'sd40, 16'sd16};
   localparam logic [HID*W-1:0] TB_WO =
      {16'sd200, 16'sd60, -16'sd90, 16'sd150};
   localparam logic [W-1:0] TB_BO = -16'sd20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          start = 1'b0;
   logic          done;
   logic          in_rd_en;
   logic [AW-1:0] in_addr;
   logic [W-1:0]  in_rdata = '0;
   logic          out_we;
   logic [AW-1:0] out_addr;
   logic [W-1:0]  out_wdata;

   always #10 clk = ~clk;

   rnn_engine #(
      .WORD_W(W), .FRAC_W(7), .HID(HID), .SEQ(SEQ),
      .WX_VEC(TB_WX), .WH_VEC(TB_WH), .BH_VEC(TB_BH),
      .WO_VEC(TB_WO), .BO_VAL(TB_BO)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done),
      .in_rd_en(in_rd_en), .in_addr(in_addr), .in_rdata(in_rdata),
      .out_we(out_we), .out_addr(out_addr), .out_wdata(out_wdata)
   );

   w16_t in_mem  [SEQ];
   w16_t out_mem [SEQ];
   w16_t exp_y   [SEQ];
   int   wr_cnt, rd_cnt;
   bit   rd_addr_err, done_early;
   int   n_chk = 0, n_bad = 0;

   always @(posedge clk) begin
      if (in_rd_en) begin
         if (int'(in_addr) < SEQ) in_rdata <= in_mem[in_addr];
         if (int'(in_addr) != rd_cnt) rd_addr_err = 1'b1;
         rd_cnt++;
      end
      if (out_we) begin
         if (int'(out_addr) < SEQ) out_mem[out_addr] <= out_wdata;
         if (done) done_early = 1'b1;
         wr_cnt++;
      end
   end

   function automatic w16_t sat16(longint v);
      if (v > 32767) return w16_t'(16'h7FFF);
      if (v < -32768) return w16_t'(16'h8000);
      return w16_t'(v);
   endfunction

   function automatic w16_t fx_mul(w16_t a, w16_t b);
      longint p = longint'(a) * longint'(b);
      return sat16(p >>> 7);
   endfunction

   function automatic w16_t fx_add(w16_t a, w16_t b);
      return sat16(longint'(a) + longint'(b));
   endfunction

   function automatic w16_t act_ref(w16_t x);
      longint v = longint'(x);
      longint a = (v < 0) ? -v : v;
      longint r;
      if (a < 64) r = a;
      else if (a < 256) r = a / 2 + 32;
      else r = 128;
      return w16_t'((v < 0) ? -r : r);
   endfunction

   task automatic build_expected();
      w16_t h [HID];
      w16_t hn [HID];
      w16_t acc;
      for (int k = 0; k < HID; k++) h[k] = '0;
      for (int t = 0; t < SEQ; t++) begin
         for (int j = 0; j < HID; j++) begin
            acc = w16_t'(TB_BH[j*W +: W]);
            acc = fx_add(acc, fx_mul(w16_t'(TB_WX[j*W +: W]), in_mem[t]));
            for (int k = 0; k < HID; k++)
               acc = fx_add(acc, fx_mul(w16_t'(TB_WH[(j*HID+k)*W +: W]), h[k]));
            hn[j] = act_ref(acc);
         end
         for (int k = 0; k < HID; k++) h[k] = hn[k];
         acc = w16_t'(TB_BO);
         for (int k = 0; k < HID; k++)
            acc = fx_add(acc, fx_mul(w16_t'(TB_WO[k*W +: W]), h[k]));
         exp_y[t] = acc;
      end
   endtask

   task automatic chk(bit ok, string req, longint act, longint exp_v);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic run_case(bit inject, output int lat);
      build_expected();
      for (int t = 0; t < SEQ; t++) out_mem[t] = w16_t'(16'hDEAD);
      wr_cnt = 0; rd_cnt = 0; rd_addr_err = 0; done_early = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(done == 1'b0, "R8 done low after start", done, 0);
      lat = 1;
      while (!done && lat < 5000) begin
         @(negedge clk);
         lat++;
         start = inject && (lat == 40);
      end
      start = 1'b0;
      chk(done == 1'b1, "R8 done reached", done, 1);
      for (int t = 0; t < SEQ; t++)
         chk(out_mem[t] == exp_y[t], "R1,R2,R3,R4,R5,R6,R11 prediction",
             out_mem[t], exp_y[t]);
      chk(wr_cnt == SEQ, "R6 write count", wr_cnt, SEQ);
      chk(rd_cnt == SEQ && !rd_addr_err, "R7 read order", rd_cnt, SEQ);
      chk(!done_early, "R8 done not before last write", done_early, 0);
      repeat (5) @(negedge clk);
      chk(done == 1'b1, "R8 done held", done, 1);
   endtask

   task automatic fill_const(w16_t v);
      for (int t = 0; t < SEQ; t++) in_mem[t] = v;
   endtask

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_up();
   end

   initial begin
      int lat_clean, lat_inj, dummy;
      int unsigned seed_init;
      seed_init = $urandom(32'd20240611);
      fill_const('0);
      #3 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!done && !in_rd_en && !out_we, "R10 reset quiet", {done, in_rd_en, out_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !in_rd_en && !out_we, "R10 after reset", {done, in_rd_en, out_we}, 0);

      // directed: zero input (bias only path), full scale, alternating signs
      fill_const('0);
      run_case(1'b0, lat_clean);
      fill_const(w16_t'(16'h7FFF));
      run_case(1'b0, dummy);
      fill_const(w16_t'(16'h8000));
      run_case(1'b0, dummy);
      for (int t = 0; t < SEQ; t++)
         in_mem[t] = (t % 2 == 0) ? w16_t'(16'h7FFF) : w16_t'(16'h8000);
      run_case(1'b0, dummy);
      // activation segment edges: 0.5 and 2.0 through WX[0] = 1.0
      in_mem[0] = 16'sd63;  in_mem[1] = 16'sd64;  in_mem[2] = -16'sd64;
      in_mem[3] = 16'sd255; in_mem[4] = 16'sd256; in_mem[5] = -16'sd256;
      run_case(1'b0, dummy);

      // constrained random
      for (int r = 0; r < 8; r++) begin
         for (int t = 0; t < SEQ; t++) begin
            if ($urandom_range(0, 3) == 0) in_mem[t] = w16_t'($urandom);
            else in_mem[t] = w16_t'(int'($urandom_range(0, 767)) - 384);
         end
         run_case(1'b0, dummy);
      end

      // R9: start pulse in the middle of a run
      fill_const('0);
      run_case(1'b1, lat_inj);
      chk(lat_inj == lat_clean, "R9 start while busy ignored", lat_inj, lat_clean);

      finish_up();
   end
endmodule